// File: doc/BRIEF.md
# ADC accumulate-and-burst sequencer

This block is the digital controller that sits next to a successive-approximation converter. It divides the function clock down to a programmable conversion clock and issues one start pulse per conversion to the converter. It also collects the 12-bit samples the converter hands back and adds a programmable number of them (1, 4, 8 or 16) into a 16-bit sum. The interrupt strobes are raised only once the whole group is complete.

A group can run in two ways. In request-per-sample operation, every conversion waits for its own convert-start. In burst operation, one convert-start launches the whole group, and the block self-times each conversion on the next conversion-clock tick after the previous sample arrives. The finished sum is copied into a visible result register in the same cycle as the strobes. The running sum is cleared at that moment, so the next group begins from zero. Dropping the enable abandons a group part-way and throws away its partial sum.

Top module: `adc_accum_seq`

## Requirements
- R1: The configuration byte comes out of reset as 0xF8. It holds the divider in bits 7:3, the group-size code in bits 2:1 and a reserved bit 0. Bit 0 always reads back 0, even when a 1 is written to it.
- R2: While enabled, `sar_tick` pulses once every (divider + 1) function-clock cycles, and `adc_start` is only ever high in a cycle where `sar_tick` is high.
- R3: The group-size code selects 1 (00), 4 (01), 8 (10) or 16 (11) conversions. `eoc_pulse` fires exactly once per group, after the last sample. `result` then holds the sum of exactly that many samples.
- R4: With `burst_en` low, each conversion needs its own `conv_start`. After one start, only one `adc_start` is issued until another `conv_start` arrives.
- R5: With `burst_en` high, a single `conv_start` produces all of the group's `adc_start` pulses, with no further request.
- R6: Each group sums from zero: the result of a group never contains samples from earlier groups.
- R7: When `left_just` is high and the group-size code is 00, the sample is placed in result bits 15:4. When the code is not 00, `left_just` is ignored and samples are summed right-justified.
- R8: `result` changes only in the cycle where `eoc_pulse` is high. Between groups it holds the last completed sum.
- R9: A `conv_start` that arrives while a conversion or burst group is in progress is ignored: no extra `adc_start` is issued and the sum is unaffected. At most one conversion is outstanding at a time.
- R10: Lowering `enable` abandons the current group with no strobe and issues no `adc_start` while it stays low. After re-enabling, the next group sums only new samples.
- R11: `eoc_pulse` and `win_pulse` are high together and for a single cycle per group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Function clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low aborts the group in progress |
| cfg_wr | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte to write |
| cfg_q | output | 8 | Configuration byte read-back |
| burst_en | input | 1 | Self-time a whole group from one request |
| left_just | input | 1 | Left-justify request, honoured only for single-conversion groups |
| conv_start | input | 1 | Convert-start request |
| sar_tick | output | 1 | One-cycle conversion-clock pulse |
| adc_start | output | 1 | Start pulse to the converter |
| adc_done | input | 1 | Converter sample valid |
| adc_sample | input | 12 | Converter sample |
| result | output | 16 | Last completed group sum |
| eoc_pulse | output | 1 | End-of-group strobe |
| win_pulse | output | 1 | Window-compare evaluation strobe |

## Verification
The bench builds the block with its default parameters: a 5-bit divider, 12-bit samples and a 16-bit sum with a group of at most 16 samples. These defaults let it run the full 0xF8 reset divider, and a burst of sixteen full-scale samples that lands exactly on 65520 without wrapping. Random groups mix every size code, both start modes, dividers 0 to 5 and a variable converter latency. Directed runs add an abort in the middle of a burst and redundant requests during a burst.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DIV_BITS    = 5;
    localparam int RPT_BITS    = 2;
    localparam int SMP_BITS    = 12;
    localparam int SUM_BITS    = 16;
    localparam int GRP_MAX     = 16;
    localparam int GCNT_BITS   = $clog2(GRP_MAX) + 1;
    localparam logic [7:0] CFG_RESET = 8'hF8;

    typedef struct packed {
        logic [DIV_BITS-1:0] div;
        logic [RPT_BITS-1:0] rpt;
    } seq_cfg_t;

    typedef enum logic [1:0] {
        CTL_IDLE = 2'd0,
        CTL_ARM  = 2'd1,
        CTL_CONV = 2'd2
    } ctl_state_t;

    function automatic logic [GCNT_BITS-1:0] group_len(input logic [RPT_BITS-1:0] code);
        case (code)
            2'b00:   group_len = GCNT_BITS'(1);
            2'b01:   group_len = GCNT_BITS'(4);
            2'b10:   group_len = GCNT_BITS'(8);
            default: group_len = GCNT_BITS'(16);
        endcase
    endfunction

endpackage

// File: rtl/adc_sar_clkdiv.sv
module adc_sar_clkdiv #(
    parameter int DIV_W = adc_seq_pkg::DIV_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase;

    assign tick = en && (phase >= div);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase <= '0;
        end else if (phase >= div) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/adc_group_ctrl.sv
module adc_group_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CNT_W = GCNT_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                burst,
    input  logic [RPT_BITS-1:0] rpt,
    input  logic                req,
    input  logic                tick,
    input  logic                conv_done,
    output logic                conv_go,
    output logic                take,
    output logic                take_last
);
    ctl_state_t       state;
    logic [CNT_W-1:0] taken;
    logic [CNT_W-1:0] need;

    assign need      = CNT_W'(group_len(rpt));
    assign conv_go   = en && (state == CTL_ARM) && tick;
    assign take      = en && (state == CTL_CONV) && conv_done;
    assign take_last = take && (taken == need - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state <= CTL_IDLE;
            taken <= '0;
        end else begin
            case (state)
                CTL_IDLE: if (req) state <= CTL_ARM;
                CTL_ARM:  if (tick) state <= CTL_CONV;
                CTL_CONV: begin
                    if (conv_done) begin
                        if (taken == need - 1'b1) begin
                            taken <= '0;
                            state <= CTL_IDLE;
                        end else begin
                            taken <= taken + 1'b1;
                            state <= burst ? CTL_ARM : CTL_IDLE;
                        end
                    end
                end
                default: state <= CTL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_accum.sv
module adc_accum #(
    parameter int SMP_W = adc_seq_pkg::SMP_BITS,
    parameter int SUM_W = adc_seq_pkg::SUM_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             take,
    input  logic             take_last,
    input  logic             ljust,
    input  logic [SMP_W-1:0] sample,
    output logic [SUM_W-1:0] result,
    output logic             eoc,
    output logic             win
);
    localparam int PAD_W = SUM_W - SMP_W;

    logic [SUM_W-1:0] running;
    logic [SUM_W-1:0] addend;
    logic [SUM_W-1:0] next_sum;

    assign addend   = ljust ? {sample, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, sample};
    assign next_sum = running + addend;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= '0;
            result  <= '0;
            eoc     <= 1'b0;
            win     <= 1'b0;
        end else begin
            eoc <= 1'b0;
            win <= 1'b0;
            if (!en) begin
                running <= '0;
            end else if (take) begin
                if (take_last) begin
                    result  <= next_sum;
                    running <= '0;
                    eoc     <= 1'b1;
                    win     <= 1'b1;
                end else begin
                    running <= next_sum;
                end
            end
        end
    end
endmodule

// File: rtl/adc_accum_seq.sv
module adc_accum_seq
    import adc_seq_pkg::*;
#(
    parameter int DIV_W = DIV_BITS,
    parameter int SMP_W = SMP_BITS,
    parameter int SUM_W = SUM_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_q,
    input  logic             burst_en,
    input  logic             left_just,
    input  logic             conv_start,
    output logic             sar_tick,
    output logic             adc_start,
    input  logic             adc_done,
    input  logic [SMP_W-1:0] adc_sample,
    output logic [SUM_W-1:0] result,
    output logic             eoc_pulse,
    output logic             win_pulse
);
    seq_cfg_t cfg;
    logic     take;
    logic     take_last;
    logic     ljust_eff;
    logic     unused_rsvd;

    assign unused_rsvd = cfg_wdata[0];
    assign cfg_q       = {cfg.div, cfg.rpt, 1'b0};
    assign ljust_eff   = left_just && (cfg.rpt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= seq_cfg_t'(CFG_RESET[7:1]);
        end else if (cfg_wr) begin
            cfg <= seq_cfg_t'(cfg_wdata[7:1]);
        end
    end

    adc_sar_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .en   (enable),
        .div  (DIV_W'(cfg.div)),
        .tick (sar_tick)
    );

    adc_group_ctrl #(.CNT_W(GCNT_BITS)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .en        (enable),
        .burst     (burst_en),
        .rpt       (cfg.rpt),
        .req       (conv_start),
        .tick      (sar_tick),
        .conv_done (adc_done),
        .conv_go   (adc_start),
        .take      (take),
        .take_last (take_last)
    );

    adc_accum #(.SMP_W(SMP_W), .SUM_W(SUM_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .en        (enable),
        .take      (take),
        .take_last (take_last),
        .ljust     (ljust_eff),
        .sample    (adc_sample),
        .result    (result),
        .eoc       (eoc_pulse),
        .win       (win_pulse)
    );
endmodule

// File: rtl/adc_accum_seq_chk.sv
module adc_accum_seq_chk #(
    parameter int SUM_W = adc_seq_pkg::SUM_BITS
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic [7:0]       cfg_q,
    input logic             sar_tick,
    input logic             adc_start,
    input logic             adc_done,
    input logic [SUM_W-1:0] result,
    input logic             eoc_pulse,
    input logic             win_pulse
);
    logic outstanding;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            outstanding <= 1'b0;
        end else if (adc_start) begin
            outstanding <= 1'b1;
        end else if (adc_done) begin
            outstanding <= 1'b0;
        end
    end

    // R1
    rsvd_bit_low_chk: assert property (@(posedge clk) disable iff (rst) cfg_q[0] == 1'b0);

    // R2
    start_on_tick_chk: assert property (@(posedge clk) disable iff (rst) adc_start |-> sar_tick);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst) !eoc_pulse |-> $stable(result));

    // R9
    single_outstanding_chk: assert property (@(posedge clk) disable iff (rst) adc_start |-> !outstanding);

    // R10
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst) !enable |-> !adc_start);

    // R11
    strobe_pair_chk: assert property (@(posedge clk) disable iff (rst) eoc_pulse == win_pulse);

    // R11
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst) eoc_pulse |=> !eoc_pulse);
endmodule

bind adc_accum_seq adc_accum_seq_chk #(.SUM_W(SUM_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .cfg_q     (cfg_q),
    .sar_tick  (sar_tick),
    .adc_start (adc_start),
    .adc_done  (adc_done),
    .result    (result),
    .eoc_pulse (eoc_pulse),
    .win_pulse (win_pulse)
);

// File: tb/adc_accum_seq_test.sv
module adc_accum_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_q;
    logic        burst_en = 1'b0;
    logic        left_just = 1'b0;
    logic        conv_start = 1'b0;
    logic        sar_tick;
    logic        adc_start;
    logic        adc_done = 1'b0;
    logic [11:0] adc_sample = 12'h000;
    logic [15:0] result;
    logic        eoc_pulse;
    logic        win_pulse;

    always #5 clk = ~clk;

    adc_accum_seq uut (
        .clk(clk), .rst(rst), .enable(enable), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_q), .burst_en(burst_en), .left_just(left_just), .conv_start(conv_start),
        .sar_tick(sar_tick), .adc_start(adc_start), .adc_done(adc_done),
        .adc_sample(adc_sample), .result(result), .eoc_pulse(eoc_pulse), .win_pulse(win_pulse)
    );

    // counters owned by the test process
    int chk_t = 0, bad_t = 0;
    // counters owned by the converter model / monitor process
    int chk_m = 0, bad_m = 0;
    // shared expectations written only by the test process
    int exp_size = 1;
    bit exp_lj = 1'b0;
    bit force_max = 1'b0;
    int clr_tok = 0;
    // state written only by the model process
    int seen_tok = 0;
    int exp_sum = 0;
    int n_done = 0;
    int n_done_tot = 0;
    int n_starts = 0;
    int n_groups = 0;
    bit busy = 1'b0;
    int lat = 0;
    logic [15:0] last_res = 16'h0;

    function automatic int size_of(input logic [1:0] code);
        return (code == 2'b00) ? 1 : (code == 2'b01) ? 4 : (code == 2'b10) ? 8 : 16;
    endfunction

    function automatic int placed(input logic [11:0] s, input bit lj);
        return lj ? int'(s) * 16 : int'(s);
    endfunction

    task automatic check_t(input bit ok, input string req, input int act, input int exp);
        chk_t++;
        if (!ok) begin
            bad_t++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_m(input bit ok, input string req, input int act, input int exp);
        chk_m++;
        if (!ok) begin
            bad_m++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // converter model and result monitor
    always @(negedge clk) begin
        logic [11:0] s;
        adc_done = 1'b0;
        if (clr_tok != seen_tok) begin
            seen_tok = clr_tok;
            exp_sum  = 0;
            n_done   = 0;
            busy     = 1'b0;
        end
        if (eoc_pulse) begin
            check_m(int'(result) == exp_sum, "R3/R6 group sum", int'(result), exp_sum);
            check_m(n_done == exp_size, "R3 samples per group", n_done, exp_size);
            check_m(win_pulse == 1'b1, "R11 window strobe with eoc", int'(win_pulse), 1);
            exp_sum = 0;
            n_done  = 0;
            n_groups++;
        end else if (win_pulse) begin
            check_m(1'b0, "R11 window strobe alone", 1, 0);
        end
        if (!eoc_pulse && result != last_res)
            check_m(1'b0, "R8 result moved without eoc", int'(result), int'(last_res));
        last_res = result;
        if (busy) begin
            if (lat == 0) begin
                s = force_max ? 12'hFFF : 12'($urandom);
                adc_sample = s;
                adc_done   = 1'b1;
                exp_sum    = exp_sum + placed(s, exp_lj);
                n_done++;
                n_done_tot++;
                busy = 1'b0;
            end else begin
                lat--;
            end
        end else if (adc_start) begin
            busy = 1'b1;
            lat  = int'($urandom % 3);
            n_starts++;
        end
    end

    task automatic set_cfg(input logic [4:0] div, input logic [1:0] rpt);
        @(negedge clk);
        cfg_wdata = {div, rpt, 1'b1};
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
    endtask

    task automatic wait_group(input int g0);
        while (n_groups == g0) @(negedge clk);
    endtask

    task automatic run_group(input logic [4:0] div, input logic [1:0] rpt,
                             input bit burst, input bit lj, input bit extra);
        int g0, s0, need;
        set_cfg(div, rpt);
        need      = size_of(rpt);
        burst_en  = burst;
        left_just = lj;
        exp_size  = need;
        exp_lj    = lj && (rpt == 2'b00);
        g0 = n_groups;
        s0 = n_starts;
        if (burst) begin
            pulse_start();
            if (extra && need > 1) begin
                repeat (2) @(negedge clk);
                pulse_start();
                pulse_start();
            end
            wait_group(g0);
            check_t(n_starts - s0 == need, "R5/R9 burst starts from one request", n_starts - s0, need);
        end else begin
            for (int i = 0; i < need; i++) begin
                int d0;
                d0 = n_done_tot;
                pulse_start();
                while (n_done_tot == d0) @(negedge clk);
            end
            wait_group(g0);
            check_t(n_starts - s0 == need, "R4 starts per request", n_starts - s0, need);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int ticks, g0, s0, d0, r0;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_t(cfg_q == 8'hF8, "R1 cfg reset", int'(cfg_q), 248);
        check_t(result == 16'h0, "R8 result reset", int'(result), 0);
        check_t(eoc_pulse == 1'b0, "R11 eoc reset", int'(eoc_pulse), 0);
        enable = 1'b1;

        // R2 reset divider: period 32
        repeat (4) @(negedge clk);
        ticks = 0;
        for (int i = 0; i < 64; i++) begin
            if (sar_tick) ticks++;
            @(negedge clk);
        end
        check_t(ticks == 2, "R2 ticks at divider 31", ticks, 2);

        // R1 reserved bit reads 0 after writing 1
        set_cfg(5'd3, 2'b01);
        check_t(cfg_q == 8'h1A, "R1 reserved bit", int'(cfg_q), 26);

        // R2 divider 3 -> period 4, divider 0 -> every cycle
        repeat (8) @(negedge clk);
        ticks = 0;
        for (int i = 0; i < 40; i++) begin
            if (sar_tick) ticks++;
            @(negedge clk);
        end
        check_t(ticks == 10, "R2 ticks at divider 3", ticks, 10);
        set_cfg(5'd0, 2'b00);
        repeat (2) @(negedge clk);
        ticks = 0;
        for (int i = 0; i < 40; i++) begin
            if (sar_tick) ticks++;
            @(negedge clk);
        end
        check_t(ticks == 40, "R2 ticks at divider 0", ticks, 40);

        // R4 request-per-sample: one start gives one conversion only
        set_cfg(5'd1, 2'b01);
        burst_en = 1'b0; left_just = 1'b0; exp_size = 4; exp_lj = 1'b0;
        g0 = n_groups; s0 = n_starts;
        pulse_start();
        repeat (60) @(negedge clk);
        check_t(n_starts - s0 == 1, "R4 single start without burst", n_starts - s0, 1);
        check_t(n_groups == g0, "R3 no eoc mid-group", n_groups, g0);
        for (int i = 0; i < 3; i++) begin
            d0 = n_done_tot;
            pulse_start();
            while (n_done_tot == d0) @(negedge clk);
        end
        wait_group(g0);
        repeat (3) @(negedge clk);

        // R7 left-justify honoured for single, ignored for groups
        run_group(5'd0, 2'b00, 1'b0, 1'b1, 1'b0);
        run_group(5'd2, 2'b01, 1'b1, 1'b1, 1'b0);

        // R9 redundant requests during a burst
        run_group(5'd0, 2'b11, 1'b1, 1'b0, 1'b1);
        run_group(5'd2, 2'b10, 1'b1, 1'b0, 1'b1);

        // R3 full-scale 16-sample burst reaches 65520
        force_max = 1'b1;
        run_group(5'd1, 2'b11, 1'b1, 1'b0, 1'b0);
        check_t(result == 16'hFFF0, "R3 full-scale sum", int'(result), 65520);
        force_max = 1'b0;

        // R10 abort in the middle of a burst
        set_cfg(5'd2, 2'b11);
        burst_en = 1'b1; left_just = 1'b0; exp_size = 16; exp_lj = 1'b0;
        r0 = int'(result);
        g0 = n_groups;
        d0 = n_done_tot;
        pulse_start();
        while (n_done_tot < d0 + 5) @(negedge clk);
        @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        s0 = n_starts;
        repeat (10) @(negedge clk);
        check_t(n_starts == s0, "R10 no starts while disabled", n_starts, s0);
        check_t(n_groups == g0, "R10 no eoc after abort", n_groups, g0);
        check_t(int'(result) == r0, "R10 result kept after abort", int'(result), r0);
        clr_tok++;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        g0 = n_groups;
        pulse_start();
        wait_group(g0);
        repeat (3) @(negedge clk);

        // R6 back-to-back groups each from zero, random mix
        for (int k = 0; k < 24; k++) begin
            logic [4:0] dv;
            logic [1:0] rp;
            dv = 5'($urandom % 6);
            rp = 2'($urandom);
            run_group(dv, rp, 1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", chk_t + chk_m, bad_t + bad_m);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", chk_t + chk_m + 1, bad_t + bad_m + 1);
        $finish;
    end
endmodule